// File: doc/BRIEF.md
# Data/Control Mode Bus Handoff Sequencer

This block decides who owns a shared serial bus when a converter moves between its streaming mode (data mode) and its configuration mode (control mode). A select input, which may change with no relation to the serial clock, picks the mode: high asks for data mode, low forces control mode. The input is resynchronised to the serial clock. The sequencer then releases or briefly drives low the frame sync, the daisy-chain token output, the serial data output and the serial clock on a fixed schedule counted in serial-clock periods. That schedule depends on two settings captured at the moment of the switch: the immediate-token-select setting and whether the device was bus master in data mode.

On every entry to control mode the sequencer pulses a load of the register defaults, which mutes the audio path. Control mode is left only after a two-step handshake on the data/control bit of received control words: a word with the bit clear, then a word with the bit set, while the select input is high. A calibration request is pulsed when reset releases and again on each return to data mode. The calibration itself and the parsing of serial words are done elsewhere. This block only sees a one-cycle strobe carrying the handshake bit of each completed word.

Top module: `dcmode_handoff`

## Requirements
- R1: While `rst_n` is low, `tsout_zero` is 1 and every other output is 0. The token output is never released in any state: there is no enable for it.
- R2: After `rst_n` rises, the outputs hold their reset values through SYNC_STAGES clock edges. At edge SYNC_STAGES+1, with `dc_sel_a` high, the block enters data mode (`data_mode`=1), and `dflt_load` and `cal_req` are each 1 for exactly that one cycle.
- R3: Under the same timing, with `dc_sel_a` low at reset release, the block enters control mode (`data_mode`=0, `sdtx_oe`=1), and `dflt_load` and `cal_req` are each pulsed for one cycle.
- R4: In data mode, `fsync_oe` and `sclk_oe` follow `is_master`, `sdtx_oe` is 1 and all `*_zero` outputs are 0. A low `dc_sel_a` takes effect SYNC_STAGES+1 edges after it is applied. The handoff window then begins and lasts HANDOVER_CYC (3) cycles, counted 0, 1 and 2.
- R5: In the handoff with ITS=0 and the device as prior master, `fsync_oe` and `fsync_zero` are 1 in cycle 0 only. `sclk_oe` is 1 in cycles 0 to 2. `sdtx_oe` is 0 throughout.
- R6: In the handoff with ITS=1 and the device as prior master, `fsync_oe`, `sclk_oe` and `sdtx_oe` are 0 from cycle 0.
- R7: In the handoff with ITS=0 and the device as prior slave, `sdtx_oe` and `sdtx_zero` are 1 in cycle 0 only. `fsync_oe` and `sclk_oe` are 0.
- R8: In the handoff with ITS=1 and the device as prior slave, `sdtx_oe`, `fsync_oe` and `sclk_oe` are 0 from cycle 0. In every handoff case, `tsout_zero` is 1 throughout.
- R9: `dflt_load` is 1 for exactly handoff cycle 0, on each entry to control mode from data mode.
- R10: After the handoff, in control mode, `sdtx_oe`=1 (the echo is driven), `fsync_oe`=`sclk_oe`=0 and all `*_zero` outputs are 0.
- R11: In control mode, a high `dc_sel_a` has no effect until a word with `word_dcb`=0 has been followed by a word with `word_dcb`=1. Words with `word_dcb`=1 that arrive before any word with 0 are ignored.
- R12: Once the handshake is complete and the synchronised select is high, `data_mode` rises on the next edge, with `cal_req` high for exactly that one cycle.
- R13: After a completed handshake, a further word with `word_dcb`=0 restarts the wait for a word with `word_dcb`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dc_sel_a | input | 1 | Asynchronous mode select, 1 = data, 0 = control |
| its_bit | input | 1 | Immediate token select setting, captured at the switch |
| is_master | input | 1 | Device is bus master in data mode |
| word_vld | input | 1 | One-cycle strobe: a control word completed |
| word_dcb | input | 1 | Data/control handshake bit of that word |
| fsync_oe | output | 1 | Frame sync output enable |
| fsync_zero | output | 1 | Force frame sync low |
| tsout_zero | output | 1 | Force token output low |
| sdtx_oe | output | 1 | Serial data output enable |
| sdtx_zero | output | 1 | Force serial data output low |
| sclk_oe | output | 1 | Serial clock output enable |
| data_mode | output | 1 | Block is in data mode |
| dflt_load | output | 1 | Pulse: load register defaults (mute) |
| cal_req | output | 1 | Pulse: request autocalibration |

## Verification
On every cycle, the assertions check these structural rules:
- a forced-low pin is always enabled;
- the serial clock is never picked up again once control mode holds it released;
- each rise of data mode comes with a calibration pulse;
- each fall of data mode comes with a default-load pulse;
- the two pulses never last longer than one cycle.

Other behaviour can only be shown by the bench's scenarios:
- the per-cycle release schedule for each of the four ITS and master combinations;
- the decision made at reset release from the select level;
- the DCB interlock order, including an early high select and a restart after a stray zero word.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

    typedef enum logic [2:0] {
        ST_INIT  = 3'd0,
        ST_DATA  = 3'd1,
        ST_HOFF  = 3'd2,
        ST_WAIT0 = 3'd3,
        ST_WAIT1 = 3'd4,
        ST_READY = 3'd5
    } dcm_state_e;

    typedef struct packed {
        logic fsync_oe;
        logic fsync_zero;
        logic tsout_zero;
        logic sdtx_oe;
        logic sdtx_zero;
        logic sclk_oe;
    } dcm_pins_t;

endpackage

// File: rtl/dcm_sync.sv
module dcm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_a,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sh_q[g] <= 1'b0;
                end else if (g == 0) begin
                    sh_q[g] <= d_a;
                end else begin
                    sh_q[g] <= sh_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/dcm_seq.sv
module dcm_seq
    import dcm_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int HANDOVER_CYC = 3,
    parameter int CNT_W        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dc_s,
    input  logic             its_bit,
    input  logic             is_master,
    input  logic             word_vld,
    input  logic             word_dcb,
    output dcm_state_e       st,
    output logic [CNT_W-1:0] cnt,
    output logic             its_cap,
    output logic             mst_cap,
    output logic             cal_pulse,
    output logic             dflt_pulse
);
    localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(SYNC_STAGES);
    localparam logic [CNT_W-1:0] HOFF_LAST = CNT_W'(HANDOVER_CYC - 1);

    typedef struct packed {
        dcm_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             its;
        logic             mst;
        logic             cal;
        logic             dflt;
    } seq_t;

    seq_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.cal  = 1'b0;
        r_d.dflt = 1'b0;
        case (r_q.st)
            ST_INIT: begin
                if (r_q.cnt == INIT_LAST) begin
                    r_d.st   = dc_s ? ST_DATA : ST_WAIT0;
                    r_d.cnt  = '0;
                    r_d.cal  = 1'b1;
                    r_d.dflt = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_DATA: begin
                if (!dc_s) begin
                    r_d.st   = ST_HOFF;
                    r_d.cnt  = '0;
                    r_d.its  = its_bit;
                    r_d.mst  = is_master;
                    r_d.dflt = 1'b1;
                end
            end
            ST_HOFF: begin
                if (r_q.cnt == HOFF_LAST) begin
                    r_d.st  = ST_WAIT0;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_WAIT0: begin
                if (word_vld && !word_dcb) r_d.st = ST_WAIT1;
            end
            ST_WAIT1: begin
                if (word_vld && word_dcb) r_d.st = ST_READY;
            end
            ST_READY: begin
                if (word_vld && !word_dcb) begin
                    r_d.st = ST_WAIT1;
                end else if (dc_s) begin
                    r_d.st  = ST_DATA;
                    r_d.cal = 1'b1;
                end
            end
            default: r_d.st = ST_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_INIT, cnt: '0, its: 1'b0, mst: 1'b0, cal: 1'b0, dflt: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign st         = r_q.st;
    assign cnt        = r_q.cnt;
    assign its_cap    = r_q.its;
    assign mst_cap    = r_q.mst;
    assign cal_pulse  = r_q.cal;
    assign dflt_pulse = r_q.dflt;
endmodule

// File: rtl/dcm_pin_dec.sv
module dcm_pin_dec
    import dcm_pkg::*;
#(
    parameter int CNT_W         = 2,
    parameter int HANDOVER_CYC  = 3,
    parameter int FSYNC_LOW_CYC = 1,
    parameter int SDTX_LOW_CYC  = 1
) (
    input  dcm_state_e       st,
    input  logic [CNT_W-1:0] cnt,
    input  logic             its_cap,
    input  logic             mst_cap,
    input  logic             live_mst,
    output dcm_pins_t        pins
);
    localparam logic [CNT_W-1:0] FS_END = CNT_W'(FSYNC_LOW_CYC);
    localparam logic [CNT_W-1:0] SD_END = CNT_W'(SDTX_LOW_CYC);
    localparam logic [CNT_W-1:0] CK_END = CNT_W'(HANDOVER_CYC);

    logic slow_mst, slow_slv;

    always_comb begin
        slow_mst = mst_cap && !its_cap;
        slow_slv = !mst_cap && !its_cap;
        pins     = '0;
        case (st)
            ST_INIT: begin
                pins.tsout_zero = 1'b1;
            end
            ST_DATA: begin
                pins.fsync_oe = live_mst;
                pins.sclk_oe  = live_mst;
                pins.sdtx_oe  = 1'b1;
            end
            ST_HOFF: begin
                pins.tsout_zero = 1'b1;
                pins.fsync_oe   = slow_mst && (cnt < FS_END);
                pins.fsync_zero = slow_mst && (cnt < FS_END);
                pins.sclk_oe    = slow_mst && (cnt < CK_END);
                pins.sdtx_oe    = slow_slv && (cnt < SD_END);
                pins.sdtx_zero  = slow_slv && (cnt < SD_END);
            end
            default: begin
                pins.sdtx_oe = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dcmode_handoff.sv
module dcmode_handoff
    import dcm_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int HANDOVER_CYC  = 3,
    parameter int FSYNC_LOW_CYC = 1,
    parameter int SDTX_LOW_CYC  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dc_sel_a,
    input  logic its_bit,
    input  logic is_master,
    input  logic word_vld,
    input  logic word_dcb,
    output logic fsync_oe,
    output logic fsync_zero,
    output logic tsout_zero,
    output logic sdtx_oe,
    output logic sdtx_zero,
    output logic sclk_oe,
    output logic data_mode,
    output logic dflt_load,
    output logic cal_req
);
    localparam int CNT_MAX = (SYNC_STAGES > HANDOVER_CYC) ? SYNC_STAGES : HANDOVER_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic             dc_s;
    dcm_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic             its_cap, mst_cap;
    dcm_pins_t        pins;

    dcm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_a(dc_sel_a), .q(dc_s)
    );

    dcm_seq #(
        .SYNC_STAGES(SYNC_STAGES), .HANDOVER_CYC(HANDOVER_CYC), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .dc_s(dc_s), .its_bit(its_bit),
        .is_master(is_master), .word_vld(word_vld), .word_dcb(word_dcb),
        .st(st), .cnt(cnt), .its_cap(its_cap), .mst_cap(mst_cap),
        .cal_pulse(cal_req), .dflt_pulse(dflt_load)
    );

    dcm_pin_dec #(
        .CNT_W(CNT_W), .HANDOVER_CYC(HANDOVER_CYC),
        .FSYNC_LOW_CYC(FSYNC_LOW_CYC), .SDTX_LOW_CYC(SDTX_LOW_CYC)
    ) u_dec (
        .st(st), .cnt(cnt), .its_cap(its_cap), .mst_cap(mst_cap),
        .live_mst(is_master), .pins(pins)
    );

    assign fsync_oe   = pins.fsync_oe;
    assign fsync_zero = pins.fsync_zero;
    assign tsout_zero = pins.tsout_zero;
    assign sdtx_oe    = pins.sdtx_oe;
    assign sdtx_zero  = pins.sdtx_zero;
    assign sclk_oe    = pins.sclk_oe;
    assign data_mode  = (st == ST_DATA);
endmodule

// File: rtl/dcmode_handoff_chk.sv
module dcmode_handoff_chk (
    input logic clk,
    input logic rst_n,
    input logic fsync_oe,
    input logic fsync_zero,
    input logic sdtx_oe,
    input logic sdtx_zero,
    input logic sclk_oe,
    input logic data_mode,
    input logic dflt_load,
    input logic cal_req
);
    // R5
    fsync_low_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_zero |-> fsync_oe);

    // R7
    sdtx_low_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdtx_zero |-> sdtx_oe);

    // R10
    sclk_no_reclaim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_oe && !data_mode) |-> $past(sclk_oe));

    // R12
    cal_on_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_mode) |-> cal_req);

    // R9
    dflt_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_mode) |-> dflt_load);

    // R2
    cal_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_req |=> !cal_req);

    // R9
    dflt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dflt_load |=> !dflt_load);
endmodule

bind dcmode_handoff dcmode_handoff_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fsync_oe(fsync_oe), .fsync_zero(fsync_zero),
    .sdtx_oe(sdtx_oe), .sdtx_zero(sdtx_zero), .sclk_oe(sclk_oe),
    .data_mode(data_mode), .dflt_load(dflt_load), .cal_req(cal_req)
);

// File: tb/dcmode_handoff_tb.sv
`timescale 1ns/1ps
module dcmode_handoff_tb;
    logic clk = 1'b0;
    logic rst_n, dc_sel_a, its_bit, is_master, word_vld, word_dcb;
    logic fsync_oe, fsync_zero, tsout_zero, sdtx_oe, sdtx_zero, sclk_oe;
    logic data_mode, dflt_load, cal_req;
    int   n_chk = 0;
    int   n_bad = 0;

    always #5 clk = ~clk;

    dcmode_handoff u_dut (
        .clk(clk), .rst_n(rst_n), .dc_sel_a(dc_sel_a), .its_bit(its_bit),
        .is_master(is_master), .word_vld(word_vld), .word_dcb(word_dcb),
        .fsync_oe(fsync_oe), .fsync_zero(fsync_zero), .tsout_zero(tsout_zero),
        .sdtx_oe(sdtx_oe), .sdtx_zero(sdtx_zero), .sclk_oe(sclk_oe),
        .data_mode(data_mode), .dflt_load(dflt_load), .cal_req(cal_req)
    );

    // order: fsync_oe fsync_zero tsout_zero sdtx_oe sdtx_zero sclk_oe data_mode dflt_load cal_req
    function automatic logic [8:0] obs();
        return {fsync_oe, fsync_zero, tsout_zero, sdtx_oe, sdtx_zero, sclk_oe,
                data_mode, dflt_load, cal_req};
    endfunction

    task automatic check(string req, logic [8:0] exp);
        logic [8:0] act;
        act = obs();
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_word(logic dcb);
        word_vld = 1'b1;
        word_dcb = dcb;
        @(posedge clk);
        @(negedge clk);
        word_vld = 1'b0;
    endtask

    function automatic logic [8:0] data_vec(logic m, logic dl, logic cr);
        return {m, 1'b0, 1'b0, 1'b1, 1'b0, m, 1'b1, dl, cr};
    endfunction

    function automatic logic [8:0] ctrl_vec(logic dl, logic cr);
        return {3'b000, 1'b1, 2'b00, 1'b0, dl, cr};
    endfunction

    // drive select low from data mode and walk the handoff window
    task automatic enter_ctrl(logic m, logic i);
        logic fo, so, co;
        its_bit   = i;
        is_master = m;
        dc_sel_a  = 1'b0;
        tick(3);
        for (int c = 0; c < 3; c++) begin
            fo = m && !i && (c < 1);
            so = !m && !i && (c < 1);
            co = m && !i && (c < 3);
            if (m && !i)       check("R5 handoff master its0", {fo, fo, 1'b1, so, so, co, 1'b0, (c == 0), 1'b0});
            else if (m && i)   check("R6 handoff master its1", {fo, fo, 1'b1, so, so, co, 1'b0, (c == 0), 1'b0});
            else if (!m && !i) check("R7 handoff slave its0",  {fo, fo, 1'b1, so, so, co, 1'b0, (c == 0), 1'b0});
            else               check("R8 handoff slave its1",  {fo, fo, 1'b1, so, so, co, 1'b0, (c == 0), 1'b0});
            tick(1);
        end
        check("R10 control mode pins", ctrl_vec(1'b0, 1'b0));
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; dc_sel_a = 1'b1; its_bit = 1'b0; is_master = 1'b1;
        word_vld = 1'b0; word_dcb = 1'b0;
        tick(2);
        check("R1 reset values", 9'b001000000);
        rst_n = 1'b1;
        tick(2);
        check("R2 still waiting for sync", 9'b001000000);
        tick(1);
        check("R2 data mode from reset", data_vec(1'b1, 1'b1, 1'b1));
        tick(1);
        check("R2 pulses single", data_vec(1'b1, 1'b0, 1'b0));

        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 2; i++) begin
                is_master = m[0];
                tick(1);
                check("R4 data mode pins", data_vec(m[0], 1'b0, 1'b0));
                enter_ctrl(m[0], i[0]);
                dc_sel_a = 1'b1;
                tick(5);
                check("R11 early select ignored", ctrl_vec(1'b0, 1'b0));
                send_word(1'b1);
                tick(3);
                check("R11 set bit first ignored", ctrl_vec(1'b0, 1'b0));
                send_word(1'b0);
                check("R11 after clear word", ctrl_vec(1'b0, 1'b0));
                send_word(1'b1);
                check("R11 handshake done", ctrl_vec(1'b0, 1'b0));
                tick(1);
                check("R12 return with calibration", data_vec(m[0], 1'b0, 1'b1));
                tick(1);
                check("R12 calibration single", data_vec(m[0], 1'b0, 1'b0));
            end
        end

        // restart of the interlock
        enter_ctrl(1'b1, 1'b0);
        send_word(1'b0);
        send_word(1'b1);
        tick(3);
        check("R11 select low holds control", ctrl_vec(1'b0, 1'b0));
        send_word(1'b0);
        dc_sel_a = 1'b1;
        tick(5);
        check("R13 restart waits for set bit", ctrl_vec(1'b0, 1'b0));
        send_word(1'b1);
        tick(1);
        check("R13 return after restart", data_vec(1'b1, 1'b0, 1'b1));

        // reset with select low
        dc_sel_a = 1'b0;
        rst_n = 1'b0;
        tick(1);
        check("R1 reset again", 9'b001000000);
        rst_n = 1'b1;
        tick(3);
        check("R3 control mode from reset", ctrl_vec(1'b1, 1'b1));
        tick(1);
        check("R3 pulses single", ctrl_vec(1'b0, 1'b0));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule